// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a cache and the next level of memory and absorbs the writes headed downward. A write is acknowledged in the cycle the buffer captures it, so the upper level continues at once. The buffer then sends its pending entries down on a drain port, one whole aligned block per transfer, at whatever pace the lower level accepts. The cache does not wait for those transfers.

Each of the four entries holds one aligned block address, the block's bytes and a valid bit per byte. When a write lands in a block that already has a pending entry, and that entry is not yet being offered downstream, the write is folded into that entry. It does not take a new slot. This lets neighbouring stores leave as a single transfer with a byte mask. A lookup port lets a pending read ask whether the buffer holds newer data for the word it needs. The buffer answers with a hit and the data, with a conflict (the read must wait for the drain), or with a miss.

Top module: `mwb_merge_buffer`

## Requirements
- R1: After reset the drain port is idle (drn_valid low), wr_ready is high and every lookup misses (lk_hit and lk_conflict both low).
- R2: wr_ready is low only when all DEPTH entries are occupied and the presented write cannot merge into any of them. A write that can merge is accepted even when every entry is occupied.
- R3: An accepted write with at least one byte enable, whose block has no mergeable entry, allocates a new entry. When drained, it carries the block-aligned address (address with the low log2(BLOCK_BYTES) bits cleared), a mask of exactly the enabled bytes, and zero in every byte never written. Byte b of the block holds wr_data bits [8*i+7:8*i] for lane i = b mod WORD_BYTES, and the word sits at offset addr[3:2] in the default shape. An accepted write with wr_be all zero changes nothing.
- R4: A write to the block of a pending entry that is not on the drain port merges into that entry. Its enabled bytes overwrite the old bytes and set their mask bits, and no new entry is taken.
- R5: Entries leave on the drain port in the order they were allocated, each exactly once.
- R6: The entry offered on the drain port (drn_valid high) is locked. Its address, data and mask stay unchanged until the transfer completes, and a write to its block allocates a new entry instead of merging.
- R7: A lookup whose newest matching entry has every requested byte valid returns lk_hit high, with those bytes of the word on lk_data.
- R8: A lookup that matches a pending block, but whose newest matching entry lacks some requested byte, returns lk_conflict high and lk_hit low. The two flags are never high together.
- R9: A lookup with no matching block, or with lk_valid low, returns both flags low.
- R10: With drn_ready held high, a full buffer empties at one entry per cycle, with no idle cycle between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Buffer accepts the write this cycle |
| wr_addr | input | ADDR_W | Byte address of the written word (word aligned) |
| wr_data | input | 8*WORD_BYTES | Write word |
| wr_be | input | WORD_BYTES | Byte enables of the word |
| drn_valid | output | 1 | Oldest entry offered to lower memory |
| drn_ready | input | 1 | Lower memory takes the offered entry |
| drn_addr | output | ADDR_W | Block-aligned address of the offered entry |
| drn_data | output | 8*BLOCK_BYTES | Block bytes of the offered entry |
| drn_mask | output | BLOCK_BYTES | Valid bytes of the offered entry |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W | Byte address of the looked-up word |
| lk_be | input | WORD_BYTES | Bytes the read needs |
| lk_hit | output | 1 | All requested bytes are buffered |
| lk_conflict | output | 1 | Block pending but bytes incomplete |
| lk_data | output | 8*WORD_BYTES | Buffered word for a hit |

## Verification
The buffer is first filled while the drain is stalled, using a stream that mixes fresh blocks, repeat writes to the offered block, partial-byte overwrites of a waiting entry and a merge into a full buffer. This separates merging from allocation and shows that the locked head is never modified. Lookups then probe full coverage, partial coverage, a block held by both an old locked entry and a newer one, and an absent block, which tells the three answers apart and shows that the newest copy is chosen. A back-to-back stream with the drain always ready checks ordering and the one-per-cycle rate, and an all-zero byte-enable write shows that an empty request leaves no trace.

// File: rtl/mwb_pkg.sv
// Shared types of the merging write buffer.
package mwb_pkg;
    // Outcome of a lookup against the pending entries.
    typedef enum logic [1:0] {
        LK_MISS     = 2'd0,
        LK_HIT      = 2'd1,
        LK_CONFLICT = 2'd2
    } lk_res_e;
endpackage

// File: rtl/mwb_slot_queue.sv
// Allocation-order bookkeeping for the buffer slots.
// Keeps an allocate pointer, a drain pointer and one occupied bit per slot.
// Assumes the caller never allocates into a full queue and never releases
// from an empty one.
module mwb_slot_queue #(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic             release_head,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic [DEPTH-1:0] occ,
    output logic             full,
    output logic             empty
);
    logic [DEPTH-1:0] occ_d;

    // Step a slot pointer forward with wrap-around.
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Next occupied vector from this cycle's allocate and release.
    always_comb begin
        occ_d = occ;
        if (release_head) occ_d[head_idx] = 1'b0;
        if (alloc)        occ_d[tail_idx] = 1'b1;
    end

    // Pointer and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_idx <= '0;
            tail_idx <= '0;
            occ      <= '0;
        end else begin
            occ <= occ_d;
            if (alloc)        tail_idx <= step(tail_idx);
            if (release_head) head_idx <= step(head_idx);
        end
    end

    assign full  = &occ;
    assign empty = ~|occ;
endmodule

// File: rtl/mwb_block_match.sv
// Compares one probe block address with every slot's block address.
// Reports whether any eligible slot matches and the youngest such slot,
// where age is counted from the drain pointer. Assumes slot_ok already
// excludes empty slots.
module mwb_block_match #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 28,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
    input  logic [DEPTH-1:0]            slot_ok,
    input  logic [PTR_W-1:0]            head_idx,
    input  logic [TAG_W-1:0]            probe,
    output logic                        any_hit,
    output logic [PTR_W-1:0]            young_idx
);
    logic [DEPTH-1:0] hit_vec;
    logic [PTR_W:0]   walk;

    // One comparator per slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = slot_ok[g] && (slot_tag[g] == probe);
    end

    assign any_hit = |hit_vec;

    // Walk from oldest to newest; the last hit seen is the youngest.
    always_comb begin
        young_idx = '0;
        walk      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            walk = {1'b0, head_idx} + (PTR_W + 1)'(k);
            if (walk >= (PTR_W + 1)'(DEPTH)) walk = walk - (PTR_W + 1)'(DEPTH);
            if (hit_vec[walk[PTR_W-1:0]]) young_idx = walk[PTR_W-1:0];
        end
    end
endmodule

// File: rtl/mwb_lookup_sel.sv
// Classifies a lookup against the chosen entry and extracts the word.
// Assumes at least two words per block.
module mwb_lookup_sel
    import mwb_pkg::*;
#(
    parameter int BLOCK_BYTES = 16,
    parameter int WORD_BYTES  = 4,
    localparam int WOFF_W = $clog2(BLOCK_BYTES / WORD_BYTES)
) (
    input  logic                      any_match,
    input  logic [BLOCK_BYTES*8-1:0]  sel_data,
    input  logic [BLOCK_BYTES-1:0]    sel_mask,
    input  logic [WOFF_W-1:0]         word_off,
    input  logic [WORD_BYTES-1:0]     req_be,
    output lk_res_e                   res,
    output logic [WORD_BYTES*8-1:0]   word_data
);
    logic [WORD_BYTES-1:0] word_mask;

    // Pick the addressed word and its valid bits out of the block.
    always_comb begin
        word_mask = sel_mask[word_off*WORD_BYTES +: WORD_BYTES];
        word_data = sel_data[word_off*WORD_BYTES*8 +: WORD_BYTES*8];
    end

    // Hit needs every requested byte; a bare block match is a conflict.
    always_comb begin
        if (!any_match)                          res = LK_MISS;
        else if ((word_mask & req_be) == req_be) res = LK_HIT;
        else                                     res = LK_CONFLICT;
    end
endmodule

// File: rtl/mwb_merge_buffer.sv
// Merging write buffer between a cache and lower memory.
// Writes are captured in a small set of block-sized entries; writes into a
// block already pending (and not on the drain port) are merged byte-wise.
// Entries drain oldest first. A lookup port reports buffered data.
// Assumes word-aligned write and lookup addresses, WORD_BYTES >= 2 and at
// least two words per block. Lookups see the state before this cycle's write.
module mwb_merge_buffer
    import mwb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 16,
    parameter int WORD_BYTES  = 4,
    parameter int DEPTH       = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    output logic                     wr_ready,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [WORD_BYTES*8-1:0]  wr_data,
    input  logic [WORD_BYTES-1:0]    wr_be,
    output logic                     drn_valid,
    input  logic                     drn_ready,
    output logic [ADDR_W-1:0]        drn_addr,
    output logic [BLOCK_BYTES*8-1:0] drn_data,
    output logic [BLOCK_BYTES-1:0]   drn_mask,
    input  logic                     lk_valid,
    input  logic [ADDR_W-1:0]        lk_addr,
    input  logic [WORD_BYTES-1:0]    lk_be,
    output logic                     lk_hit,
    output logic                     lk_conflict,
    output logic [WORD_BYTES*8-1:0]  lk_data
);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int WB_W   = $clog2(WORD_BYTES);
    localparam int WOFF_W = OFF_W - WB_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int BLK_W  = BLOCK_BYTES * 8;
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][TAG_W-1:0]       tag_q;
    logic [DEPTH-1:0][BLK_W-1:0]       data_q;
    logic [DEPTH-1:0][BLOCK_BYTES-1:0] mask_q;

    logic [PTR_W-1:0] head_idx, tail_idx, wr_idx, lk_idx;
    logic [DEPTH-1:0] occ, locked, merge_ok;
    logic             full, empty;
    logic             wr_any, lk_any;
    logic             wr_fire, do_merge, do_alloc, pop;
    logic [TAG_W-1:0] wr_tag, lk_tag;
    logic [WOFF_W-1:0] wr_woff, lk_woff;
    logic [BLOCK_BYTES-1:0] lane_mask;
    logic [BLK_W-1:0]       lane_data, lane_bits;
    lk_res_e                lk_res;
    logic                   unused_low_bits;

    assign wr_tag  = wr_addr[ADDR_W-1:OFF_W];
    assign lk_tag  = lk_addr[ADDR_W-1:OFF_W];
    assign wr_woff = wr_addr[OFF_W-1:WB_W];
    assign lk_woff = lk_addr[OFF_W-1:WB_W];
    assign unused_low_bits = ^{wr_addr[WB_W-1:0], lk_addr[WB_W-1:0], empty};

    // Slot ordering and occupancy.
    mwb_slot_queue #(.DEPTH(DEPTH)) u_queue (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc        (do_alloc),
        .release_head (pop),
        .head_idx     (head_idx),
        .tail_idx     (tail_idx),
        .occ          (occ),
        .full         (full),
        .empty        (empty)
    );

    // The oldest entry is offered downstream and locked while offered.
    always_comb begin
        locked           = '0;
        locked[head_idx] = drn_valid;
    end

    assign drn_valid = occ[head_idx];
    assign drn_addr  = {tag_q[head_idx], {OFF_W{1'b0}}};
    assign drn_data  = data_q[head_idx];
    assign drn_mask  = mask_q[head_idx];
    assign pop       = drn_valid & drn_ready;
    assign merge_ok  = occ & ~locked;

    // Search for a merge target among unlocked pending entries.
    mwb_block_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_wr_match (
        .slot_tag  (tag_q),
        .slot_ok   (merge_ok),
        .head_idx  (head_idx),
        .probe     (wr_tag),
        .any_hit   (wr_any),
        .young_idx (wr_idx)
    );

    // Write acceptance and the choice between merge and allocation.
    assign wr_ready = wr_any | ~full;
    assign wr_fire  = wr_valid & wr_ready;
    assign do_merge = wr_fire & (|wr_be) & wr_any;
    assign do_alloc = wr_fire & (|wr_be) & ~wr_any;

    // Spread the write word and its enables across the block lanes.
    always_comb begin
        for (int b = 0; b < BLOCK_BYTES; b++) begin
            lane_mask[b]        = (WOFF_W'(b / WORD_BYTES) == wr_woff) && wr_be[b % WORD_BYTES];
            lane_data[b*8 +: 8] = lane_mask[b] ? wr_data[(b % WORD_BYTES)*8 +: 8] : 8'h00;
            lane_bits[b*8 +: 8] = {8{lane_mask[b]}};
        end
    end

    // Entry storage: fresh fill on allocation, byte overwrite on merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else begin
            if (do_alloc) begin
                tag_q[tail_idx]  <= wr_tag;
                data_q[tail_idx] <= lane_data;
                mask_q[tail_idx] <= lane_mask;
            end
            if (do_merge) begin
                data_q[wr_idx] <= (data_q[wr_idx] & ~lane_bits) | lane_data;
                mask_q[wr_idx] <= mask_q[wr_idx] | lane_mask;
            end
        end
    end

    // Search for the newest pending copy of the looked-up block.
    mwb_block_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_lk_match (
        .slot_tag  (tag_q),
        .slot_ok   (occ),
        .head_idx  (head_idx),
        .probe     (lk_tag),
        .any_hit   (lk_any),
        .young_idx (lk_idx)
    );

    // Classify the lookup against that entry.
    mwb_lookup_sel #(.BLOCK_BYTES(BLOCK_BYTES), .WORD_BYTES(WORD_BYTES)) u_lk_sel (
        .any_match (lk_valid & lk_any),
        .sel_data  (data_q[lk_idx]),
        .sel_mask  (mask_q[lk_idx]),
        .word_off  (lk_woff),
        .req_be    (lk_be),
        .res       (lk_res),
        .word_data (lk_data)
    );

    assign lk_hit      = (lk_res == LK_HIT);
    assign lk_conflict = (lk_res == LK_CONFLICT);
endmodule

// File: rtl/mwb_merge_buffer_chk.sv
// Protocol and ordering checks for the merging write buffer.
module mwb_merge_buffer_chk #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_valid,
    input logic                     wr_ready,
    input logic                     drn_valid,
    input logic                     drn_ready,
    input logic [ADDR_W-1:0]        drn_addr,
    input logic [BLOCK_BYTES*8-1:0] drn_data,
    input logic [BLOCK_BYTES-1:0]   drn_mask,
    input logic                     lk_hit,
    input logic                     lk_conflict,
    input logic                     q_full
);
    // R1: the first cycle out of reset is idle and ready.
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!drn_valid && wr_ready));

    // R2: a free slot always means the write is taken.
    assert_ready_if_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q_full |-> wr_ready);

    // R2: a refused write only happens with every slot in use.
    assert_stall_only_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |-> q_full);

    // R3: an offered entry always carries at least one byte.
    assert_entry_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drn_valid |-> (drn_mask != '0));

    // R6: the offered entry holds still until it is taken.
    assert_head_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_addr)
                                       && $stable(drn_data) && $stable(drn_mask)));

    // R8: hit and conflict never coincide.
    assert_lookup_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_conflict));
endmodule

bind mwb_merge_buffer mwb_merge_buffer_chk #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_ready    (wr_ready),
    .drn_valid   (drn_valid),
    .drn_ready   (drn_ready),
    .drn_addr    (drn_addr),
    .drn_data    (drn_data),
    .drn_mask    (drn_mask),
    .lk_hit      (lk_hit),
    .lk_conflict (lk_conflict),
    .q_full      (full)
);

// File: tb/mwb_merge_buffer_tb_top.sv
// Scoreboard bench: stimulus tasks queue the expected drain transfers,
// a monitor compares each completed transfer against the queue head.
module mwb_merge_buffer_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [31:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_be = '0;
    logic         drn_valid;
    logic         drn_ready = 1'b0;
    logic [31:0]  drn_addr;
    logic [127:0] drn_data;
    logic [15:0]  drn_mask;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic [3:0]   lk_be = '0;
    logic         lk_hit;
    logic         lk_conflict;
    logic [31:0]  lk_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0]  a;
        logic [127:0] d;
        logic [15:0]  m;
    } drain_item_t;
    drain_item_t exp_q[$];

    always #10 clk = ~clk;

    mwb_merge_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_addr(drn_addr),
        .drn_data(drn_data), .drn_mask(drn_mask),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_be(lk_be),
        .lk_hit(lk_hit), .lk_conflict(lk_conflict), .lk_data(lk_data)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] put_bytes(input logic [127:0] blk, input logic [31:0] a,
                                               input logic [31:0] d, input logic [3:0] be);
        for (int i = 0; i < 4; i++)
            if (be[i]) blk[(a[3:2]*4 + i)*8 +: 8] = d[i*8 +: 8];
        return blk;
    endfunction

    function automatic logic [15:0] put_mask(input logic [15:0] m, input logic [31:0] a,
                                             input logic [3:0] be);
        for (int i = 0; i < 4; i++)
            if (be[i]) m[a[3:2]*4 + i] = 1'b1;
        return m;
    endfunction

    task automatic expect_drain(input logic [31:0] a, input logic [127:0] d, input logic [15:0] m);
        drain_item_t e;
        e.a = a; e.d = d; e.m = m;
        exp_q.push_back(e);
    endtask

    // Called just after a rising edge; returns just after the next one.
    task automatic drive_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                               input bit exp_ready, input string req);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(negedge clk);
        chk(wr_ready == exp_ready, req, 128'(wr_ready), 128'(exp_ready));
        @(posedge clk); #1;
        wr_valid = 1'b0; wr_be = '0;
    endtask

    task automatic probe(input logic v, input logic [31:0] a, input logic [3:0] be,
                         input bit exp_hit, input bit exp_conf, input logic [31:0] exp_word,
                         input string req);
        lk_valid = v; lk_addr = a; lk_be = be;
        @(negedge clk);
        chk(lk_hit == exp_hit, {req, " hit"}, 128'(lk_hit), 128'(exp_hit));
        chk(lk_conflict == exp_conf, {req, " conflict"}, 128'(lk_conflict), 128'(exp_conf));
        if (exp_hit) begin
            logic [31:0] bm;
            for (int i = 0; i < 4; i++) bm[i*8 +: 8] = {8{be[i]}};
            chk((lk_data & bm) == (exp_word & bm), {req, " data"}, 128'(lk_data & bm), 128'(exp_word & bm));
        end
        @(posedge clk); #1;
        lk_valid = 1'b0;
    endtask

    // Monitor: compare every completed drain transfer with the queue.
    always @(negedge clk) begin
        if (rst_n && drn_valid && drn_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected drain", 128'(drn_addr), 128'(0));
            end else begin
                drain_item_t e;
                e = exp_q.pop_front();
                chk(drn_addr == e.a, "R5 drain address order", 128'(drn_addr), 128'(e.a));
                chk(drn_data == e.d, "R4 drain data", drn_data, e.d);
                chk(drn_mask == e.m, "R3 drain mask", 128'(drn_mask), 128'(e.m));
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 128'(0), 128'(1));
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] d1, d2, d3, d4;
        logic [15:0]  m1, m2, m3, m4;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: idle after reset.
        lk_valid = 1'b1; lk_addr = 32'h100; lk_be = 4'hF;
        @(negedge clk);
        chk(drn_valid == 1'b0, "R1 drain idle", 128'(drn_valid), 128'(0));
        chk(wr_ready == 1'b1, "R1 write ready", 128'(wr_ready), 128'(1));
        chk(!lk_hit && !lk_conflict, "R1 lookup miss", 128'({lk_hit, lk_conflict}), 128'(0));
        @(posedge clk); #1 lk_valid = 1'b0;

        // Fill with the drain stalled.
        d1 = put_bytes('0, 32'h100, 32'h11223344, 4'hF); m1 = put_mask('0, 32'h100, 4'hF);
        drive_write(32'h100, 32'h11223344, 4'hF, 1'b1, "R3 first write accepted");
        // R6: same block as the offered head -> new entry.
        d2 = put_bytes('0, 32'h104, 32'hA5A5A5A5, 4'hF); m2 = put_mask('0, 32'h104, 4'hF);
        drive_write(32'h104, 32'hA5A5A5A5, 4'hF, 1'b1, "R6 write to locked block accepted");
        // R4: merges into the second entry.
        d2 = put_bytes(d2, 32'h108, 32'h01020304, 4'hF); m2 = put_mask(m2, 32'h108, 4'hF);
        drive_write(32'h108, 32'h01020304, 4'hF, 1'b1, "R4 merge accepted");
        d2 = put_bytes(d2, 32'h108, 32'h0000BEEF, 4'h3); m2 = put_mask(m2, 32'h108, 4'h3);
        drive_write(32'h108, 32'h0000BEEF, 4'h3, 1'b1, "R4 partial overwrite accepted");
        d3 = put_bytes('0, 32'h20C, 32'hCAFEF00D, 4'h8); m3 = put_mask('0, 32'h20C, 4'h8);
        drive_write(32'h20C, 32'hCAFEF00D, 4'h8, 1'b1, "R3 single byte write accepted");
        d4 = put_bytes('0, 32'h300, 32'h55667788, 4'hC); m4 = put_mask('0, 32'h300, 4'hC);
        drive_write(32'h300, 32'h55667788, 4'hC, 1'b1, "R3 fourth entry accepted");

        // R2: full and no merge target -> stall; merge target -> accept.
        drive_write(32'h400, 32'hDEADDEAD, 4'hF, 1'b0, "R2 full buffer stalls new block");
        d4 = put_bytes(d4, 32'h30C, 32'h99999999, 4'h1); m4 = put_mask(m4, 32'h30C, 4'h1);
        drive_write(32'h30C, 32'h99999999, 4'h1, 1'b1, "R2 merge accepted while full");
        d2 = put_bytes(d2, 32'h100, 32'h00000077, 4'h1); m2 = put_mask(m2, 32'h100, 4'h1);
        drive_write(32'h100, 32'h00000077, 4'h1, 1'b1, "R6 merge skips locked head");

        // R6: head stays on the port unchanged while stalled.
        @(negedge clk);
        chk(drn_valid && drn_addr == 32'h100, "R6 head offered", 128'(drn_addr), 128'(32'h100));
        chk(drn_mask == m1 && drn_data == d1, "R6 head unchanged", drn_data, d1);
        @(posedge clk); #1;

        // Lookups.
        probe(1'b1, 32'h108, 4'hF, 1'b1, 1'b0, 32'h0102BEEF, "R7 merged word hit");
        probe(1'b1, 32'h104, 4'h3, 1'b1, 1'b0, 32'hA5A5A5A5, "R7 partial request hit");
        probe(1'b1, 32'h100, 4'h1, 1'b1, 1'b0, 32'h00000077, "R7 newest copy returned");
        probe(1'b1, 32'h100, 4'h2, 1'b0, 1'b1, 32'h0, "R8 newest copy lacks byte");
        probe(1'b1, 32'h30C, 4'hF, 1'b0, 1'b1, 32'h0, "R8 partial coverage");
        probe(1'b1, 32'h600, 4'hF, 1'b0, 1'b0, 32'h0, "R9 absent block");
        probe(1'b0, 32'h108, 4'hF, 1'b0, 1'b0, 32'h0, "R9 lookup not valid");

        // R5 and R10: release the drain, four transfers back to back.
        expect_drain(32'h100, d1, m1);
        expect_drain(32'h100, d2, m2);
        expect_drain(32'h200, d3, m3);
        expect_drain(32'h300, d4, m4);
        drn_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(drn_valid == 1'b1, "R10 drain every cycle", 128'(drn_valid), 128'(1));
        end
        @(negedge clk);
        chk(drn_valid == 1'b0, "R10 buffer empty after four", 128'(drn_valid), 128'(0));
        chk(exp_q.size() == 0, "R5 all entries drained", 128'(exp_q.size()), 128'(0));
        @(posedge clk); #1;

        // R3: write with no byte enables leaves nothing behind.
        drive_write(32'h700, 32'h12121212, 4'h0, 1'b1, "R3 empty write accepted");
        @(negedge clk);
        chk(drn_valid == 1'b0, "R3 empty write allocates nothing", 128'(drn_valid), 128'(0));
        @(posedge clk); #1;
        probe(1'b1, 32'h700, 4'hF, 1'b0, 1'b0, 32'h0, "R3 empty write not visible");

        // R5/R6: streaming with the drain always ready.
        expect_drain(32'h800, put_bytes('0, 32'h800, 32'hDEADBEEF, 4'hF), put_mask('0, 32'h800, 4'hF));
        expect_drain(32'h800, put_bytes('0, 32'h804, 32'h12345678, 4'hF), put_mask('0, 32'h804, 4'hF));
        expect_drain(32'h810, put_bytes('0, 32'h818, 32'hC0C0C0C0, 4'h6), put_mask('0, 32'h818, 4'h6));
        drive_write(32'h800, 32'hDEADBEEF, 4'hF, 1'b1, "R5 stream write one");
        drive_write(32'h804, 32'h12345678, 4'hF, 1'b1, "R6 stream write during head drain");
        drive_write(32'h818, 32'hC0C0C0C0, 4'h6, 1'b1, "R5 stream write three");
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R5 stream fully drained", 128'(exp_q.size()), 128'(0));
        chk(drn_valid == 1'b0, "R10 idle after stream", 128'(drn_valid), 128'(0));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule